// File: doc/BRIEF.md
# Wiper Setting Store Sequencer

This block holds the live settings of four 8-bit wiper channels and keeps a nonvolatile copy of each. After power-on reset it copies every stored word into its live wiper on the internal clock alone, without waiting for any serial clock activity. A serial front end hands it decoded commands:

- a trial write that changes one live wiper,
- a read that returns one stored word,
- a store that copies one live wiper into its nonvolatile word.

The live value of a wiper is only provisional. While chip select is low, every wiper is reloaded from its stored word on each clock. A store is only accepted while the program-enable input is high. The store then advances only on falling-edge strobes of the serial clock that the front end passes in. Throughout that time the sequencer holds its ready output low for a programmable number of strobes. The nonvolatile array is modelled as a register file whose write port has a fixed latency of `WR_LAT` clocks. A supply-fault abort input cancels a store in flight and sets an error flag.

Top module: `wiper_store_seq`

## Requirements
- R1: While reset is high, ready is low. At the first clock after reset is released, every wiper takes its stored word without any serial strobe, and ready goes high. Each channel i has the factory stored word 0x3C + 0x21*i (0x3C, 0x5D, 0x7E, 0x9F).
- R2: A write command (op 2'b01) with chip select high, in the idle state, sets the addressed wiper to cmd_data at the next clock. The stored word is left unchanged.
- R3: A read command (op 2'b10) raises rd_valid for one cycle after the next clock, with rd_data equal to the addressed channel's stored word. It leaves every wiper unchanged and is also served while a store is pending or busy.
- R4: While chip select is low, every wiper is reloaded from its stored word at each clock. A write command in that time has no effect.
- R5: A store command (op 2'b11) is accepted only in the idle state, with chip select and program-enable both high. Otherwise it leaves ready high and the stored word unchanged, however many strobes follow.
- R6: After a store is accepted, ready stays high until the first sck_fall strobe and falls at the clock that samples it. It then stays low through EW_CYC further strobes and WR_LAT more clocks, and rises together with the commit. After the commit, the channel's stored word equals the wiper value captured when the store was accepted.
- R7: An abort pulse while a store is pending or busy returns ready high at the next clock and sets err_o. It leaves the stored word unchanged. err_o clears when the next store is accepted.
- R8: Write and store commands that arrive while a store is pending or busy have no effect on the wipers or the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs | input | 1 | Chip select; high keeps trial wiper values, low reloads them |
| prog_en | input | 1 | Program enable; must be high for a store to be accepted |
| sck_fall | input | 1 | One-cycle strobe per falling serial clock edge |
| abort_in | input | 1 | Supply-fault abort of a store in flight |
| cmd_valid | input | 1 | Command strobe from the serial front end |
| cmd_op | input | 2 | 00 none, 01 write, 10 read, 11 store |
| cmd_ch | input | 2 | Channel addressed by the command |
| cmd_data | input | 8 | Data for a write command |
| wiper_o | output | 32 | Live wiper settings, channel i at bits [8i+7:8i] |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Stored word returned by a read |
| ready | output | 1 | High when no erase/write cycle is running |
| err_o | output | 1 | Set by an aborted store |

## Verification
The hardest situation to reach is a command arriving in the middle of an erase/write cycle. It only exists while strobes are withheld, so the bench accepts a store and issues one strobe to enter the busy state. It then sends a write, a second store and a read while no strobes run, before resuming the strobe count. The aborted store is set up the same way: a store is armed, partly counted and cancelled, and the stored word and error flag are then read back through the ports.

// File: rtl/wss_pkg.sv
package wss_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_STORE = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_ARMED,
        ST_BUSY,
        ST_SETTLE
    } seq_st_e;

    // Factory content of the nonvolatile word of channel idx.
    function automatic logic [31:0] factory_word(input int idx);
        return 32'h3C + 32'h21 * idx;
    endfunction

endpackage

// File: rtl/wss_nv_array.sv
module wss_nv_array
    import wss_pkg::*;
#(
    parameter int NCH = 4,
    parameter int WW  = 8,
    parameter int LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_ch,
    input  logic [WW-1:0]          wr_data,
    output logic [NCH*WW-1:0]      words_o
);
    localparam int CHW = $clog2(NCH);

    logic [LAT-1:0] pv;
    logic [CHW-1:0] pa [LAT];
    logic [WW-1:0]  pd [LAT];
    logic [WW-1:0]  mem [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            pv <= '0;
            for (int k = 0; k < LAT; k++) begin
                pa[k] <= '0;
                pd[k] <= '0;
            end
            for (int i = 0; i < NCH; i++) begin
                mem[i] <= WW'(factory_word(i));
            end
        end else begin
            pv[0] <= wr_en;
            pa[0] <= wr_ch;
            pd[0] <= wr_data;
            for (int k = 1; k < LAT; k++) begin
                pv[k] <= pv[k-1];
                pa[k] <= pa[k-1];
                pd[k] <= pd[k-1];
            end
            if (pv[LAT-1]) begin
                mem[pa[LAT-1]] <= pd[LAT-1];
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign words_o[g*WW +: WW] = mem[g];
    end

    // R6: one store commits exactly one word, so the pipe never holds two writes
    assert_single_inflight_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pv));

endmodule

// File: rtl/wss_ew_timer.sv
module wss_ew_timer #(
    parameter int EW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(EW + 1);

    logic [CW-1:0] cnt;

    assign done = tick && (cnt == CW'(EW - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick && (cnt != CW'(EW))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the count only moves on a strobe
    assert_count_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ($past(tick) || $past(clear)));

endmodule

// File: rtl/wss_wiper_bank.sv
module wss_wiper_bank #(
    parameter int NCH = 4,
    parameter int WW  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reload,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_ch,
    input  logic [WW-1:0]          wr_data,
    input  logic [NCH*WW-1:0]      nv_words,
    output logic [NCH*WW-1:0]      wipers_o
);
    logic [WW-1:0] w [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) w[i] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (reload) begin
                    w[i] <= nv_words[i*WW +: WW];
                end else if (wr_en && (int'(wr_ch) == i)) begin
                    w[i] <= wr_data;
                end
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign wipers_o[g*WW +: WW] = w[g];
    end

    // R4: a reload copies the stored words into every wiper
    assert_reload_copies_R4: assert property (@(posedge clk) disable iff (rst)
        reload |=> (wipers_o == $past(nv_words)));

endmodule

// File: rtl/wiper_store_seq.sv
module wiper_store_seq
    import wss_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int WW     = 8,
    parameter int EW_CYC = 16,
    parameter int WR_LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs,
    input  logic                   prog_en,
    input  logic                   sck_fall,
    input  logic                   abort_in,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [$clog2(NCH)-1:0] cmd_ch,
    input  logic [WW-1:0]          cmd_data,
    output logic [NCH*WW-1:0]      wiper_o,
    output logic                   rd_valid,
    output logic [WW-1:0]          rd_data,
    output logic                   ready,
    output logic                   err_o
);
    localparam int CHW = $clog2(NCH);
    localparam int SW  = $clog2(WR_LAT + 1);

    seq_st_e        st;
    op_e            op;
    logic [CHW-1:0] cap_ch;
    logic [WW-1:0]  cap_data;
    logic [SW-1:0]  settle_cnt;
    logic [NCH*WW-1:0] nv_words;

    logic wr_go, store_go, reload, tmr_done, nv_we, in_store;

    assign op       = op_e'(cmd_op);
    assign in_store = (st == ST_ARMED) || (st == ST_BUSY);
    assign wr_go    = cmd_valid && (op == OP_WRITE) && (st == ST_IDLE) && cs;
    assign store_go = cmd_valid && (op == OP_STORE) && (st == ST_IDLE) && cs && prog_en;
    assign reload   = (st == ST_LOAD) || !cs;
    assign nv_we    = (st == ST_BUSY) && tmr_done && !abort_in;
    assign ready    = (st == ST_IDLE) || (st == ST_ARMED);

    wss_nv_array #(.NCH(NCH), .WW(WW), .LAT(WR_LAT)) u_nv (
        .clk(clk), .rst(rst), .wr_en(nv_we), .wr_ch(cap_ch),
        .wr_data(cap_data), .words_o(nv_words)
    );

    wss_ew_timer #(.EW(EW_CYC)) u_tmr (
        .clk(clk), .rst(rst), .clear(st == ST_ARMED),
        .tick((st == ST_BUSY) && sck_fall), .done(tmr_done)
    );

    wss_wiper_bank #(.NCH(NCH), .WW(WW)) u_wip (
        .clk(clk), .rst(rst), .reload(reload), .wr_en(wr_go),
        .wr_ch(cmd_ch), .wr_data(cmd_data), .nv_words(nv_words),
        .wipers_o(wiper_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_LOAD;
            cap_ch     <= '0;
            cap_data   <= '0;
            settle_cnt <= '0;
            err_o      <= 1'b0;
        end else begin
            case (st)
                ST_LOAD: st <= ST_IDLE;
                ST_IDLE: begin
                    if (store_go) begin
                        cap_ch   <= cmd_ch;
                        cap_data <= wiper_o[cmd_ch*WW +: WW];
                        err_o    <= 1'b0;
                        st       <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (abort_in) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end else if (sck_fall) begin
                        st <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (abort_in) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end else if (tmr_done) begin
                        settle_cnt <= '0;
                        st         <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SW'(WR_LAT - 1)) begin
                        st <= ST_IDLE;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cmd_valid && (op == OP_READ) && (st != ST_LOAD);
            rd_data  <= nv_words[cmd_ch*WW +: WW];
        end
    end

    // R6: busy begins only on a serial falling-edge strobe
    assert_busy_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(sck_fall));

    // R6: stored words change only as a store finishes settling
    assert_nv_commit_only_R6: assert property (@(posedge clk) disable iff (rst)
        (nv_words != $past(nv_words)) |-> ($past(st) == ST_SETTLE));

    // R5: a store is armed only with program enable high
    assert_prog_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ARMED) && ($past(st) == ST_IDLE)) |-> $past(prog_en && cs));

    // R7: the error flag is raised only by an abort
    assert_err_from_abort_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(abort_in));

    // R8: with chip select high, wipers hold while a store is in flight
    assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(in_store) && $past(cs)) |-> (wiper_o == $past(wiper_o)));

endmodule

// File: tb/tb_wiper_store_seq.sv
module tb_wiper_store_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EW  = 16;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b1, prog_en = 1'b0, sck_fall = 1'b0, abort_in = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [1:0]  cmd_ch = 2'd0;
    logic [7:0]  cmd_data = 8'h00;
    logic [31:0] wiper_o;
    logic        rd_valid, ready, err_o;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;

    // channel, data
    localparam logic [9:0] VEC [6] = '{
        {2'd0, 8'h00}, {2'd1, 8'hFF}, {2'd2, 8'h5A},
        {2'd3, 8'h81}, {2'd0, 8'hC3}, {2'd3, 8'h01}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_store_seq #(.NCH(4), .WW(8), .EW_CYC(EW), .WR_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .cs(cs), .prog_en(prog_en), .sck_fall(sck_fall),
        .abort_in(abort_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ch(cmd_ch), .cmd_data(cmd_data), .wiper_o(wiper_o),
        .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready), .err_o(err_o)
    );

    function automatic logic [7:0] fac(input int i);
        return 8'(8'h3C + 8'h21 * i);
    endfunction

    function automatic logic [7:0] wip(input int i);
        return wiper_o[i*8 +: 8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input int ch, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ch = 2'(ch); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic strobe(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); sck_fall = 1'b1;
            @(negedge clk); sck_fall = 1'b0;
        end
    endtask

    task automatic read_chk(input string req, input int ch, input logic [7:0] exp);
        cmd(2'b10, ch, 8'h00);
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] snap;
        // R1: reset and power-up load
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'd0, ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) check("R1 power-up load", {24'd0, wip(i)}, {24'd0, fac(i)});
        check("R1 ready after load", {31'd0, ready}, 32'd1);

        // R2/R3: vector table of trial writes and readbacks
        for (int v = 0; v < 6; v++) begin
            int ch;
            ch = int'(VEC[v][9:8]);
            cmd(2'b01, ch, VEC[v][7:0]);
            check("R2 trial write", {24'd0, wip(ch)}, {24'd0, VEC[v][7:0]});
            snap = wiper_o;
            read_chk("R3 readback stored", ch, fac(ch));
            check("R3 read leaves wipers", wiper_o, snap);
        end

        // R4: chip select low reloads everything, writes ignored
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) check("R4 restore", {24'd0, wip(i)}, {24'd0, fac(i)});
        cmd(2'b01, 0, 8'h77);
        check("R4 write ignored", {24'd0, wip(0)}, {24'd0, fac(0)});
        @(negedge clk); cs = 1'b1;

        // R5: store without program enable has no effect
        cmd(2'b01, 2, 8'hA5);
        prog_en = 1'b0;
        cmd(2'b11, 2, 8'h00);
        strobe(EW + 3);
        check("R5 ready stays high", {31'd0, ready}, 32'd1);
        read_chk("R5 stored unchanged", 2, fac(2));

        // R6/R8: full store with commands while busy
        cmd(2'b01, 0, 8'h44);
        prog_en = 1'b1;
        cmd(2'b11, 2, 8'h00);
        check("R6 ready before strobe", {31'd0, ready}, 32'd1);
        strobe(1);
        check("R6 busy on first strobe", {31'd0, ready}, 32'd0);
        cmd(2'b01, 3, 8'hEE);
        check("R8 write ignored while busy", {24'd0, wip(3)}, {24'd0, fac(3)});
        cmd(2'b11, 0, 8'h00);
        read_chk("R3 read while busy", 2, fac(2));
        strobe(EW - 1);
        check("R6 still busy", {31'd0, ready}, 32'd0);
        strobe(1);
        repeat (LAT - 1) @(negedge clk);
        check("R6 busy through latency", {31'd0, ready}, 32'd0);
        @(negedge clk);
        check("R6 ready after commit", {31'd0, ready}, 32'd1);
        read_chk("R6 stored captured value", 2, 8'hA5);
        read_chk("R8 ignored store", 0, fac(0));
        check("R7 no error", {31'd0, err_o}, 32'd0);

        // R7: abort in mid-cycle
        cmd(2'b01, 1, 8'h11);
        cmd(2'b11, 1, 8'h00);
        strobe(3);
        @(negedge clk); abort_in = 1'b1;
        @(negedge clk); abort_in = 1'b0;
        check("R7 ready after abort", {31'd0, ready}, 32'd1);
        check("R7 error set", {31'd0, err_o}, 32'd1);
        strobe(EW + 4);
        check("R7 stays ready", {31'd0, ready}, 32'd1);
        read_chk("R7 stored unchanged", 1, fac(1));
        cmd(2'b01, 3, 8'h66);
        cmd(2'b11, 3, 8'h00);
        check("R7 error cleared", {31'd0, err_o}, 32'd0);
        strobe(EW + 1);
        repeat (LAT + 1) @(negedge clk);
        read_chk("R6 second store", 3, 8'h66);

        // R4: reload now reflects committed words
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
        check("R4 restore ch1", {24'd0, wip(1)}, {24'd0, fac(1)});
        check("R4 restore ch2", {24'd0, wip(2)}, 32'hA5);
        check("R4 restore ch3", {24'd0, wip(3)}, 32'h66);
        cs = 1'b1;

        finish_run();
    end
endmodule